// File: doc/BRIEF.md
# Scatter-Gather Bus Master DMA Engine

This block moves sector data between system memory and a disk data port without the processor copying each word. Software fills a table of 8-byte descriptors in memory, writes the table's address into the engine and sets the start bit. The engine then fetches descriptors one after another and moves 16-bit words between the addressed memory buffers and the device. It moves a word only while the device holds its request line high. Direction is selected by a command bit.

Each descriptor holds two little-endian 32-bit words. The first word is the buffer address, which is forced even. The second word gives the byte length in its low 16 bits, forced even, where a length of zero means 65536 bytes. Bit 31 of the second word marks the last entry of the table. The host sees two 32-bit registers. Word 0 carries the command byte in bits 7:0 and the status byte in bits 23:16. Word 1 is the descriptor table pointer. A rising edge on the device interrupt input latches a status flag, which software clears by writing a one to it.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, register word 0 and word 1 both read 0, and no memory access or device acknowledge is presented.
- R2: A write to register word 1 (reg_addr = 1) stores the table pointer with bits 1:0 read back as zero.
- R3: In word 0, only command bit 0 (start) and bit 3 (direction, 1 = device to memory) can be written, and the other command bits read 0. Status bits 21 and 22 (byte bits 5 and 6) are plain read/write. Status bits 19, 20 and 23 read 0. Writing status bit 16 does not set the active flag.
- R4: A 0-to-1 change of the start bit sets the active flag (word 0 bit 16), clears the remaining length, and makes the first memory access a read at the table pointer.
- R5: Writing 1 to word 0 bit 17 (error) or bit 18 (interrupt) clears that flag, and writing 0 leaves it unchanged. The same write stores bits 21 and 22.
- R6: A rising edge of dev_irq sets bit 18. A level that is held high does not set it again after it has been cleared. An edge in the same cycle as a write-1-to-clear leaves the bit set.
- R7: Descriptors are read as four 16-bit halfwords at consecutive even addresses. Address bit 0 is cleared, and the length is the low 16 bits with bit 0 cleared, where 0 means 65536 bytes. Bit 31 marks the last descriptor. After a non-final descriptor drains, the next one is fetched 8 bytes further on.
- R8: Each device acknowledge moves one 16-bit word at the current buffer address, which then advances by 2. The low byte is at the lower address. With direction 0 memory is read and the word appears on dev_wdata. With direction 1 dev_rdata is written to memory.
- R9: A data access starts only while dev_req and the active flag are both high. While dev_req is low, the engine only fetches descriptors.
- R10: When the last descriptor's length reaches zero, the active flag clears in the same cycle. Further device requests cause no memory access and leave the error bit at 0.
- R11: Writing start = 0 while active clears the active flag at once. At most one memory access that is already outstanding completes, and no further accesses follow.
- R12: Once mem_valid is raised, it stays high with mem_addr and mem_we unchanged until mem_ready is sampled high. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register word select: 0 command/status, 1 table pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address, always even |
| mem_wdata | output | 16 | Memory write halfword, low byte at mem_addr |
| mem_ready | input | 1 | Memory completes the access in this cycle |
| mem_rdata | input | 16 | Memory read halfword, valid with mem_ready |
| dev_req | input | 1 | Device requests a data word |
| dev_rdata | input | 16 | Word from the device, held until dev_ack |
| dev_ack | output | 1 | One word moved in this cycle |
| dev_wdata | output | 16 | Word to the device, valid with dev_ack |
| dev_irq | input | 1 | Device interrupt, edge sensitive |

## Verification
Two events can land in the same clock edge. One is the host write-1-to-clear of the interrupt flag. The other is a rising edge of the device interrupt. The bench provokes this by raising dev_irq in the same cycle as the clearing register write, then reads word 0 and expects the flag still set. The same area is exercised by a second case: a descriptor's final word completing in the cycle in which the done condition clears the active flag. After that cycle the bench keeps the request line high and expects no further memory traffic and no error.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 16;
    localparam int LENF_W     = 16;
    localparam int LEN_W      = LENF_W + 1;
    localparam int WORD_BYTES = WORD_W / 8;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;
    localparam int ST_RUN  = 16;
    localparam int ST_ERR  = 17;
    localparam int ST_INT  = 18;
    localparam int ST_CAP0 = 21;
    localparam int ST_CAP1 = 22;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic              last;
    } desc_t;

    function automatic logic [LEN_W-1:0] decode_len(input logic [LENF_W-1:0] raw);
        logic [LENF_W-1:0] even;
        even = {raw[LENF_W-1:1], 1'b0};
        return (even == '0) ? LEN_W'(1 << LENF_W) : {1'b0, even};
    endfunction
endpackage

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
    import sg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_irq,
    input  logic              xfer_done,
    output logic              start_pulse,
    output logic              active,
    output logic              dir,
    output logic              irq_flag,
    output logic [ADDR_W-1:0] table_ptr
);
    logic              go_q, dir_q, run_q, err_q, int_q, irq_prev_q;
    logic [1:0]        cap_q;
    logic [ADDR_W-3:0] tbl_q;
    logic              wr_ctl, wr_tbl, irq_edge;

    assign wr_ctl      = reg_wr && !reg_addr;
    assign wr_tbl      = reg_wr && reg_addr;
    assign start_pulse = wr_ctl && reg_wdata[CMD_GO] && !go_q;
    assign irq_edge    = dev_irq && !irq_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q <= 1'b0; dir_q <= 1'b0; run_q <= 1'b0; err_q <= 1'b0;
            int_q <= 1'b0; irq_prev_q <= 1'b0; cap_q <= '0; tbl_q <= '0;
        end else begin
            irq_prev_q <= dev_irq;
            if (xfer_done) run_q <= 1'b0;
            if (wr_ctl) begin
                go_q  <= reg_wdata[CMD_GO];
                dir_q <= reg_wdata[CMD_DIR];
                cap_q <= reg_wdata[ST_CAP1:ST_CAP0];
                if (reg_wdata[ST_ERR]) err_q <= 1'b0;
                if (reg_wdata[ST_INT]) int_q <= 1'b0;
                if (start_pulse)                       run_q <= 1'b1;
                else if (!reg_wdata[CMD_GO] && go_q)   run_q <= 1'b0;
            end
            if (irq_edge) int_q <= 1'b1;
            if (wr_tbl) tbl_q <= reg_wdata[ADDR_W-1:2];
        end
    end

    always_comb begin
        if (reg_addr) reg_rdata = {tbl_q, 2'b00};
        else reg_rdata = {8'h00, 1'b0, cap_q, 2'b00, int_q, err_q, run_q,
                          8'h00, 4'h0, dir_q, 2'b00, go_q};
    end

    assign active    = run_q;
    assign dir       = dir_q;
    assign irq_flag  = int_q;
    assign table_ptr = {tbl_q, 2'b00};
endmodule

// File: rtl/sg_dma_desc_asm.sv
module sg_dma_desc_asm
    import sg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] hword,
    output desc_t             desc,
    output logic              complete
);
    logic [1:0]        idx_q;
    logic [WORD_W-1:0] lo_q, hi_q, len_q;

    assign complete = load && (idx_q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0; lo_q <= '0; hi_q <= '0; len_q <= '0;
        end else if (load) begin
            idx_q <= idx_q + 2'd1;
            case (idx_q)
                2'd0:    lo_q  <= hword;
                2'd1:    hi_q  <= hword;
                2'd2:    len_q <= hword;
                default: ;
            endcase
        end
    end

    always_comb begin
        desc.base = {hi_q, lo_q[WORD_W-1:1], 1'b0};
        desc.len  = decode_len(len_q);
        desc.last = hword[WORD_W-1];
    end
endmodule

// File: rtl/sg_dma_mover.sv
module sg_dma_mover
    import sg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              dir,
    input  logic [ADDR_W-1:0] table_ptr,
    input  logic              dev_req,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic              dev_ack,
    output logic [WORD_W-1:0] dev_wdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic              is_fetch
);
    logic              valid_q, we_q, fetch_q, last_q;
    logic [ADDR_W-1:0] addr_q, dptr_q, baddr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [LEN_W-1:0]  rem_q;
    logic              xfer, data_done, asm_done;
    desc_t             nxt;

    assign xfer      = valid_q && mem_ready;
    assign data_done = xfer && !fetch_q && active && (rem_q != '0);
    assign done      = data_done && last_q && (rem_q == LEN_W'(WORD_BYTES));
    assign dev_ack   = data_done;
    assign dev_wdata = mem_rdata;

    sg_dma_desc_asm u_asm (
        .clk(clk), .rst(rst), .clear(start),
        .load(xfer && fetch_q), .hword(mem_rdata),
        .desc(nxt), .complete(asm_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0; we_q <= 1'b0; fetch_q <= 1'b0; last_q <= 1'b0;
            addr_q <= '0; dptr_q <= '0; baddr_q <= '0; wdata_q <= '0; rem_q <= '0;
        end else begin
            if (xfer) begin
                valid_q <= 1'b0;
                if (fetch_q) begin
                    dptr_q <= dptr_q + ADDR_W'(WORD_BYTES);
                    if (asm_done) begin
                        baddr_q <= nxt.base;
                        rem_q   <= nxt.len;
                        last_q  <= nxt.last;
                    end
                end else if (data_done) begin
                    baddr_q <= baddr_q + ADDR_W'(WORD_BYTES);
                    rem_q   <= rem_q - LEN_W'(WORD_BYTES);
                end
            end else if (!valid_q && active && !start) begin
                if (rem_q == '0) begin
                    if (!last_q) begin
                        valid_q <= 1'b1; we_q <= 1'b0; fetch_q <= 1'b1;
                        addr_q  <= dptr_q;
                    end
                end else if (dev_req) begin
                    valid_q <= 1'b1; we_q <= dir; fetch_q <= 1'b0;
                    addr_q  <= baddr_q; wdata_q <= dev_rdata;
                end
            end
            if (start) begin
                dptr_q <= table_ptr;
                rem_q  <= '0;
                last_q <= 1'b0;
            end
        end
    end

    assign mem_valid = valid_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign is_fetch  = fetch_q;
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              dev_req,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic              dev_ack,
    output logic [WORD_W-1:0] dev_wdata,
    input  logic              dev_irq
);
    logic              start_w, active_w, dir_w, irq_w, done_w, fetch_w;
    logic [ADDR_W-1:0] tbl_w;

    sg_dma_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_irq(dev_irq),
        .xfer_done(done_w), .start_pulse(start_w), .active(active_w),
        .dir(dir_w), .irq_flag(irq_w), .table_ptr(tbl_w)
    );

    sg_dma_mover u_mover (
        .clk(clk), .rst(rst), .start(start_w), .active(active_w), .dir(dir_w),
        .table_ptr(tbl_w), .dev_req(dev_req), .dev_rdata(dev_rdata),
        .dev_ack(dev_ack), .dev_wdata(dev_wdata), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done_w),
        .is_fetch(fetch_w)
    );
endmodule

// File: rtl/sg_dma_checker.sv
module sg_dma_checker
    import sg_dma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_req,
    input logic              dev_ack,
    input logic              dev_irq,
    input logic              active,
    input logic              irq_flag,
    input logic              done,
    input logic              is_fetch
);
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) && !is_fetch |-> $past(dev_req) && $past(active));

    p_irq_edge_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |=> irq_flag);

    p_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !active);

    p_ack_r8: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> mem_valid && mem_ready);

    p_align_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !mem_addr[0]);
endmodule

bind sg_dma_engine sg_dma_checker i_chk (
    .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_irq(dev_irq), .active(active_w), .irq_flag(irq_w), .done(done_w),
    .is_fetch(fetch_w)
);

// File: tb/test_sg_dma_engine.sv
`timescale 1ns/1ps
module test_sg_dma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;
    logic        dev_req = 1'b0, dev_ack, dev_irq = 1'b0;

    int total = 0, fails = 0;
    logic [7:0]  mem [4096];
    logic        rdy_alt = 1'b0, rdy_q = 1'b0;
    int          ack_n = 0, acc_n = 0, viol = 0;
    logic [15:0] rx [64];
    logic [31:0] acc_addr [64];
    logic        wait_q = 1'b0;
    logic [31:0] wait_addr = '0;

    always #10 clk = ~clk;

    sg_dma_engine i_sg_dma_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .dev_req(dev_req),
        .dev_rdata(dev_rdata), .dev_ack(dev_ack), .dev_wdata(dev_wdata),
        .dev_irq(dev_irq)
    );

    assign mem_ready = rdy_alt ? rdy_q : 1'b1;
    assign mem_rdata = {mem[(mem_addr[11:0] + 12'd1)], mem[mem_addr[11:0]]};
    assign dev_rdata = 16'h1122 + 16'(ack_n) * 16'h2222;

    always @(posedge clk) begin
        rdy_q <= ~rdy_q;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[11:0]]          <= mem_wdata[7:0];
                mem[mem_addr[11:0] + 12'd1]  <= mem_wdata[15:8];
            end
            if (acc_n < 64) acc_addr[acc_n] <= mem_addr;
            acc_n <= acc_n + 1;
        end
        if (dev_ack) begin
            if (ack_n < 64) rx[ack_n] <= dev_wdata;
            ack_n <= ack_n + 1;
        end
        if (wait_q && (!mem_valid || mem_addr != wait_addr)) viol <= viol + 1;
        wait_q    <= mem_valid && !mem_ready;
        wait_addr <= mem_addr;
    end

    // {addr, write data, expected read-back}
    localparam logic [64:0] VEC [6] = '{
        {1'b1, 32'h0000_1237, 32'h0000_1234},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFC},
        {1'b0, 32'h0000_00FE, 32'h0000_0008},
        {1'b0, 32'h00FF_0000, 32'h0060_0000},
        {1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 32'h0000_0100, 32'h0000_0100}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[(a + i) % 4096] = v[8*i +: 8];
    endtask

    task automatic wait_idle(input int lim);
        logic [31:0] s;
        for (int i = 0; i < lim; i++) begin
            rd(1'b0, s);
            if (!s[16]) break;
        end
    endtask

    task automatic clr_counts();
        @(negedge clk); ack_n = 0; acc_n = 0;
    endtask

    initial begin
        logic [31:0] r;
        int snap;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        rd(1'b0, r); check("R1 word0", r, 32'h0);
        rd(1'b1, r); check("R1 word1", r, 32'h0);
        check("R1 idle bus", {30'h0, mem_valid, dev_ack}, 32'h0);

        for (int k = 0; k < 6; k++) begin
            wr(VEC[k][64], VEC[k][63:32]);
            rd(VEC[k][64], r);
            check(VEC[k][64] ? "R2 table ptr" : "R3 cmd/status", r, VEC[k][31:0]);
        end

        // interrupt flag: edge set, W1C, level hold, same-cycle collision
        wr(1'b0, 32'h0060_0000);
        @(negedge clk); dev_irq = 1'b1;
        rd(1'b0, r); check("R6 edge sets int", r, 32'h0064_0000);
        wr(1'b0, 32'h0066_0000);
        rd(1'b0, r); check("R5 w1c int keeps cap", r, 32'h0060_0000);
        repeat (3) @(negedge clk);
        rd(1'b0, r); check("R6 level no reset", r, 32'h0060_0000);
        @(negedge clk); dev_irq = 1'b0;
        @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0064_0000; dev_irq = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(1'b0, r); check("R6 edge beats w1c", r, 32'h0064_0000);
        dev_irq = 1'b0;
        wr(1'b0, 32'h0004_0000);
        rd(1'b0, r); check("R5 w1c then zero", r, 32'h0);

        // A: memory to device, chained descriptors, stalling memory
        put32(32'h100, 32'h0000_0201); put32(32'h104, 32'h0000_0007);
        put32(32'h108, 32'h0000_0300); put32(32'h10C, 32'h8000_0004);
        rdy_alt = 1'b1;
        wr(1'b1, 32'h100);
        clr_counts();
        dev_req = 1'b1;
        wr(1'b0, 32'h1);
        rd(1'b0, r); check("R4 start sets active", {31'h0, r[16]}, 32'h1);
        wait_idle(400);
        check("R7 chain word count", ack_n, 5);
        check("R4 first fetch at table", acc_addr[0], 32'h100);
        check("R7 base bit0 cleared", acc_addr[4], 32'h200);
        check("R7 next desc +8", acc_addr[7], 32'h108);
        check("R7 second buffer", acc_addr[11], 32'h300);
        check("R8 word0 little endian", rx[0], {mem[12'h201], mem[12'h200]});
        check("R8 word2", rx[2], {mem[12'h205], mem[12'h204]});
        check("R8 word4", rx[4], {mem[12'h303], mem[12'h302]});
        snap = acc_n;
        repeat (20) @(negedge clk);
        check("R10 no access after drain", acc_n, snap);
        rd(1'b0, r); check("R10 idle no error", r & 32'h0003_0000, 32'h0);
        check("R12 held while stalled", viol, 0);
        dev_req = 1'b0;
        wr(1'b0, 32'h0);

        // B: device to memory, request gating
        put32(32'h400, 32'h0000_0600); put32(32'h404, 32'h8000_0006);
        wr(1'b1, 32'h400);
        clr_counts();
        wr(1'b0, 32'h9);
        repeat (30) @(negedge clk);
        check("R9 fetch only without request", acc_n, 4);
        dev_req = 1'b1;
        wait_idle(200);
        dev_req = 1'b0;
        check("R8 dev->mem count", ack_n, 3);
        check("R8 bytes 600", {mem[12'h603], mem[12'h602], mem[12'h601], mem[12'h600]}, 32'h3344_1122);
        check("R8 bytes 604", {16'h0, mem[12'h605], mem[12'h604]}, 32'h5566);
        wr(1'b0, 32'h0);

        // C: abort
        put32(32'h800, 32'h0000_0A00); put32(32'h804, 32'h8000_0040);
        wr(1'b1, 32'h800);
        clr_counts();
        dev_req = 1'b1;
        wr(1'b0, 32'h1);
        for (int i = 0; i < 200 && ack_n < 3; i++) @(negedge clk);
        wr(1'b0, 32'h0);
        rd(1'b0, r); check("R11 abort clears active", {31'h0, r[16]}, 32'h0);
        repeat (5) @(negedge clk);
        snap = acc_n;
        repeat (20) @(negedge clk);
        check("R11 no traffic after abort", acc_n, snap);
        check("R11 partial count", (ack_n < 32) ? 32'h1 : 32'h0, 32'h1);
        dev_req = 1'b0;

        // E: zero length means 65536 bytes
        rdy_alt = 1'b0;
        put32(32'hC00, 32'h0000_0000); put32(32'hC04, 32'h8000_0000);
        wr(1'b1, 32'hC00);
        clr_counts();
        dev_req = 1'b1;
        wr(1'b0, 32'h1);
        wait_idle(150000);
        dev_req = 1'b0;
        check("R7 zero length = 65536 bytes", ack_n, 32768);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule